// File: doc/BRIEF.md
# Periodic Auto-Reload Down-Counter Timer

A register-mapped countdown timer for a peripheral bus. The counter is 16 or 32 bits wide, chosen by a parameter. Each tick it takes from one of two externally generated strobes, a slow one and a fast one, lowers the count by one. When a tick arrives with the count at zero, the counter underflows and raises a level interrupt. That interrupt stays high until software writes the clear register. On underflow, periodic mode reloads the counter from the load register, while free-running mode wraps it to all ones.

Software sets the timer up in three writes. The first writes control with counting off. The second writes the load register with N-1. The third writes control again with counting on. A load write made while counting is off also presets the counter, so the first period is already a full N ticks. After that, an interrupt arrives once every N selected ticks. The bus port is a single-cycle write strobe with a combinational read path. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `cdtimer`

## Requirements
- R1: After reset the load, count and control registers read zero and `irq` is low.
- R2: The count drops by exactly one on each selected tick while control bit 7 (enable) is set. It does not change on any tick while that bit is clear.
- R3: Control bit 3 selects the tick source: 1 uses `tick_fast` and 0 uses `tick_slow`. A strobe on the source that is not selected has no effect on the count.
- R4: When control bit 6 is 1 (periodic), a selected tick at count zero reloads the count from the load register. A load value of N-1 therefore gives one underflow every N selected ticks.
- R5: When control bit 6 is 0 (free-running), a selected tick at count zero sets the count to all ones.
- R6: A load-register write made while enable is clear also sets the count to the written value. A load write made while enable is set leaves the count alone and takes effect at the next reload.
- R7: Every underflow sets `irq`. It stays high until a write of any data to the clear register drops it in the following cycle.
- R8: If a clear write and an underflow occur in the same cycle, `irq` stays high.
- R9: The registers sit at these byte offsets: 0x0 load (read/write), 0x4 live count (read only), 0x8 control (read/write), 0xC clear (write only, reads zero). Only bits 7, 6 and 3 of control are stored, and all other control bits read zero.
- R10: Write-data bits above the counter width are dropped, and the load and count registers read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| tick_slow | input | 1 | One-cycle strobe from the slow prescaler |
| tick_fast | input | 1 | One-cycle strobe from the fast prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Sticky underflow interrupt level |

## Verification
The bench builds the block with its 16-bit default counter. This keeps the all-ones wrap value short enough to check directly, and it exercises the zero-extension of the count and load registers onto the 32-bit bus. Upper write-data bits are sent on purpose to show they are dropped. Small load values in the random phase produce frequent underflows, so reloads, wraps, clears that coincide with an underflow, and load writes on both sides of the enable bit all occur many times.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef enum logic [1:0] {
    REG_LOAD  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_CLEAR = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_EN_BIT   = 7;
  localparam int unsigned CTRL_PER_BIT  = 6;
  localparam int unsigned CTRL_FAST_BIT = 3;

  typedef struct packed {
    logic en;
    logic periodic;
    logic fast;
  } ctrl_t;

endpackage

// File: rtl/cdt_rst_sync.sv
module cdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/cdt_regfile.sv
module cdt_regfile
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  load_q,
  output logic              load_wr,
  output logic              clear_wr
);
  reg_sel_e          sel;
  logic              ctrl_wr;
  ctrl_t             ctrl_d;
  logic [CNT_W-1:0]  load_d;

  assign sel = reg_sel_e'(bus_addr[3:2]);

  always_comb begin
    ctrl_wr  = bus_wr && (sel == REG_CTRL);
    load_wr  = bus_wr && (sel == REG_LOAD);
    clear_wr = bus_wr && (sel == REG_CLEAR);
    ctrl_d   = ctrl_q;
    load_d   = load_q;
    if (ctrl_wr) begin
      ctrl_d.en       = bus_wdata[CTRL_EN_BIT];
      ctrl_d.periodic = bus_wdata[CTRL_PER_BIT];
      ctrl_d.fast     = bus_wdata[CTRL_FAST_BIT];
    end
    if (load_wr) load_d = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_q <= '0;
    else if (load_wr) load_q <= load_d;
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl_q,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic [CNT_W-1:0] load_q,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic             underflow
);
  logic             tick_sel;
  logic             at_zero;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] wrap_val;

  always_comb begin
    tick_sel  = ctrl_q.en && (ctrl_q.fast ? tick_fast : tick_slow);
    at_zero   = (cnt_q == '0);
    underflow = tick_sel && at_zero;
    wrap_val  = ctrl_q.periodic ? load_q : {CNT_W{1'b1}};
    cnt_en    = tick_sel || (load_wr && !ctrl_q.en);
    cnt_d     = cnt_q;
    if (tick_sel)                  cnt_d = at_zero ? wrap_val : cnt_q - 1'b1;
    else if (load_wr && !ctrl_q.en) cnt_d = load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic underflow,
  input  logic clear_wr,
  output logic irq_q
);
  logic irq_d;
  logic irq_en;

  always_comb begin
    irq_en = underflow || clear_wr;
    irq_d  = underflow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end
endmodule

// File: rtl/cdtimer.sv
module cdtimer
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_slow,
  input  logic              tick_fast,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int unsigned PAD_W = BUS_W - CNT_W;

  logic             rst_core_n;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cnt_q;
  logic             load_wr;
  logic             clear_wr;
  logic             underflow;
  logic [BUS_W-1:0] load_rd;
  logic [BUS_W-1:0] cnt_rd;
  logic [BUS_W-1:0] ctrl_rd;
  logic             unused_bits;

  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  cdt_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  cdt_regfile #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_q    (ctrl_q),
    .load_q    (load_q),
    .load_wr   (load_wr),
    .clear_wr  (clear_wr)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ctrl_q    (ctrl_q),
    .tick_slow (tick_slow),
    .tick_fast (tick_fast),
    .load_q    (load_q),
    .load_wr   (load_wr),
    .load_data (bus_wdata[CNT_W-1:0]),
    .cnt_q     (cnt_q),
    .underflow (underflow)
  );

  cdt_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .underflow (underflow),
    .clear_wr  (clear_wr),
    .irq_q     (irq)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign load_rd = {{PAD_W{1'b0}}, load_q};
      assign cnt_rd  = {{PAD_W{1'b0}}, cnt_q};
    end else begin : g_full
      assign load_rd = load_q;
      assign cnt_rd  = cnt_q;
    end
  endgenerate

  always_comb begin
    ctrl_rd                = '0;
    ctrl_rd[CTRL_EN_BIT]   = ctrl_q.en;
    ctrl_rd[CTRL_PER_BIT]  = ctrl_q.periodic;
    ctrl_rd[CTRL_FAST_BIT] = ctrl_q.fast;
    unique case (reg_sel_e'(bus_addr[3:2]))
      REG_LOAD:  bus_rdata = load_rd;
      REG_COUNT: bus_rdata = cnt_rd;
      REG_CTRL:  bus_rdata = ctrl_rd;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_slow,
  input logic              tick_fast,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              en,
  input logic              periodic,
  input logic              fast,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  load,
  input logic              irq
);
  logic chk_tick;
  logic chk_uf;
  logic chk_clear;
  logic chk_loadw;

  assign chk_tick  = en && (fast ? tick_fast : tick_slow);
  assign chk_uf    = chk_tick && (cnt == '0);
  assign chk_clear = bus_wr && (bus_addr[3:2] == 2'd3);
  assign chk_loadw = bus_wr && (bus_addr[3:2] == 2'd0);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_tick && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_tick && !(chk_loadw && !en)) |=> $stable(cnt));

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_uf && periodic) |=> cnt == $past(load));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_uf && !periodic) |=> &cnt);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !chk_clear) |=> irq);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_clear && !chk_uf) |=> !irq);

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !chk_uf) |=> !irq);

  p_uf_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_uf |=> irq);
endmodule

bind cdtimer cdt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .tick_slow (tick_slow),
  .tick_fast (tick_fast),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .en        (ctrl_q.en),
  .periodic  (ctrl_q.periodic),
  .fast      (ctrl_q.fast),
  .cnt       (cnt_q),
  .load      (load_q),
  .irq       (irq)
);

// File: tb/cdtimer_bench.sv
`timescale 1ns/1ps
module cdtimer_bench;
  localparam int W = 16;
  localparam logic [3:0] A_LOAD = 4'h0, A_CNT = 4'h4, A_CTRL = 4'h8, A_CLR = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_slow, tick_fast, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  int n_vec = 0, n_fail = 0;
  bit done = 0;

  logic [W-1:0] m_cnt, m_load;
  logic [7:0]   m_ctrl;
  logic         m_irq;

  always #2 clk = ~clk;

  cdtimer u_cdtimer (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a[3:2])
      2'd0:    return {16'h0, m_load};
      2'd1:    return {16'h0, m_cnt};
      2'd2:    return {24'h0, m_ctrl};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step(input logic wr, input logic [3:0] a,
                            input logic [31:0] d, input logic ts, input logic tf);
    logic t, uf;
    logic [W-1:0] nc;
    t  = m_ctrl[7] && (m_ctrl[3] ? tf : ts);
    uf = t && (m_cnt == 0);
    nc = m_cnt;
    if (t) nc = uf ? (m_ctrl[6] ? m_load : {W{1'b1}}) : m_cnt - 1'b1;
    if (wr && a[3:2] == 2'd0) begin
      if (!m_ctrl[7]) nc = d[W-1:0];
      m_load = d[W-1:0];
    end
    if (wr && a[3:2] == 2'd2) m_ctrl = d[7:0] & 8'hC8;
    if (uf) m_irq = 1'b1;
    else if (wr && a[3:2] == 2'd3) m_irq = 1'b0;
    m_cnt = nc;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [3:0] a, input logic [31:0] d,
                     input logic ts, input logic tf);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; tick_slow = ts; tick_fast = tf;
    @(posedge clk);
    model_step(wr, a, d, ts, tf);
    #1;
    bus_wr = 1'b0; tick_slow = 1'b0; tick_fast = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic tk(input logic ts, input logic tf, input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, A_CNT, 32'h0, ts, tf);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_wr = 1'b0; tick_slow = 1'b0; tick_fast = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic irq_is(input logic exp, input string tag);
    @(negedge clk);
    chk(tag, {31'h0, irq}, {31'h0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    rst_n = 1'b0; tick_slow = 0; tick_fast = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    m_cnt = 0; m_load = 0; m_ctrl = 0; m_irq = 0;
    seed_dummy = $urandom(32'd1234);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_LOAD, 0, "R1 load");
    rd(A_CNT,  0, "R1 count");
    rd(A_CTRL, 0, "R1 ctrl");
    irq_is(1'b0, "R1 irq");

    // R6 preset while disabled, R9 ctrl readback
    wr(A_CTRL, 32'h48);
    wr(A_LOAD, 32'd4);
    rd(A_CNT, 4, "R6 preset");
    wr(A_CTRL, 32'hC8);
    rd(A_CTRL, 32'hC8, "R9 ctrl");
    // R3 unselected slow strobe ignored
    tk(1'b1, 1'b0, 3);
    rd(A_CNT, 4, "R3 slow ignored");
    // R2 decrement
    tk(1'b0, 1'b1, 4);
    rd(A_CNT, 0, "R2 decrement");
    irq_is(1'b0, "R4 no early irq");
    // R4 period N=5
    tk(1'b0, 1'b1, 1);
    irq_is(1'b1, "R4 irq on fifth tick");
    rd(A_CNT, 4, "R4 reload");
    // R6 load while enabled
    wr(A_LOAD, 32'd9);
    rd(A_CNT, 4, "R6 enabled load no preset");
    rd(A_LOAD, 9, "R6 load reg");
    // R7 clear
    wr(A_CLR, 32'h0);
    irq_is(1'b0, "R7 clear");
    // R8 coincident clear and underflow
    tk(1'b0, 1'b1, 4);
    rd(A_CNT, 0, "R2 reach zero");
    cyc(1'b1, A_CLR, 32'h1, 1'b0, 1'b1);
    irq_is(1'b1, "R8 underflow wins");
    rd(A_CNT, 9, "R4 new load used");
    tk(1'b0, 1'b0, 2);
    tk(1'b0, 1'b1, 1);
    irq_is(1'b1, "R7 sticky");
    rd(A_CNT, 8, "R2 after reload");
    wr(A_CLR, 32'hDEAD);
    irq_is(1'b0, "R7 clear any data");
    // R5 free-running wrap
    wr(A_CTRL, 32'h08);
    wr(A_LOAD, 32'd1);
    wr(A_CTRL, 32'h88);
    tk(1'b0, 1'b1, 2);
    rd(A_CNT, 32'hFFFF, "R5 wrap");
    irq_is(1'b1, "R5 irq");
    tk(1'b0, 1'b1, 1);
    rd(A_CNT, 32'hFFFE, "R5 continue");
    // R2 disabled
    wr(A_CTRL, 32'h00);
    tk(1'b1, 1'b1, 3);
    rd(A_CNT, 32'hFFFE, "R2 disabled hold");
    // R9 masking, R10 width
    wr(A_CTRL, 32'hFF);
    rd(A_CTRL, 32'hC8, "R9 ctrl mask");
    wr(A_LOAD, 32'hABCD1234);
    rd(A_LOAD, 32'h1234, "R10 load truncated");
    rd(A_CLR, 0, "R9 clear reads zero");

    // random phase against bench model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r, d;
      logic [3:0]  a;
      r = $urandom;
      a = {r[1:0], 2'b00};
      d = (r[4:2] == 0) ? $urandom : {28'h0, r[11:8]};
      if (a == A_CTRL) d = {24'h0, r[15:8]} | 32'h80 * {31'h0, r[16]};
      cyc(r[20:18] == 0, a, d, r[21], r[22]);
      rd({r[25:24], 2'b00}, model_read({r[25:24], 2'b00}), "R2 R4 R5 R6 random");
      irq_is(m_irq, "R7 R8 random irq");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule